// File: doc/BRIEF.md
# Continuous-Phase FFSK Bit Modulator

This block turns host-supplied data words into a fast frequency-shift keyed tone whose phase never jumps. A phase accumulator advances once per sample-clock enable by an increment chosen from the current bit value and the selected baud rate. The accumulator value is the output sample: it can index a sine table, and its top bit is a ready-made square wave. At the default 9600 samples per second, a bit lasts 8 samples at 1200 baud or 4 samples at 2400 baud. A 1 is sent as 1200 Hz. A 0 is sent as 1800 Hz at the low rate and 2400 Hz at the high rate. Each bit therefore covers a fixed fraction of a tone cycle.

The host writes a word and its baud choice into a holding register. The modulator moves the word into a shifter and sends it MSB first. A word written before the current one finishes follows it with no gap. To end a transmission, the host raises a last-data strobe. The modulator then sends one extra hang bit, clears busy, and can raise an interrupt. If the holding register runs dry without last-data, the block stops and raises an underrun flag.

Top module: `ffsk_modulator`

## Requirements
- R1: After reset, phaseOut is 0 and busy, doneIrq and underrun are all 0.
- R2: At 1200 baud (baudSel=0), a 1 bit lasts 8 sample enables, and each adds 8192 to the 16-bit phase. That is one full 1200 Hz cycle.
- R3: At 1200 baud, a 0 bit lasts 8 sample enables, and each adds 12288. That is one and a half 1800 Hz cycles.
- R4: At 2400 baud (baudSel=1), a 1 bit lasts 4 sample enables, and each adds 8192. That is half a 1200 Hz cycle.
- R5: At 2400 baud, a 0 bit lasts 4 sample enables, and each adds 16384. That is one 2400 Hz cycle.
- R6: The phase is never reset at bit or word boundaries. It changes only on clocks where sampleEn is high and the modulator is sending. toneSign equals phaseOut bit 15.
- R7: Each word is sent MSB (bit 7) first and LSB last.
- R8: If a word is written while another is being sent, it starts on the sample enable after the current word's last sample, with no idle sample in between.
- R9: A lastSet pulse, given before the final word ends, appends one hang bit after that word. The hang bit repeats the final data bit at that word's baud rate, and busy clears on its last sample enable.
- R10: doneIrq pulses high for one clock, on the edge where busy clears after the hang bit, only if irqEn is 1. It never pulses on underrun.
- R11: If a word ends with the holding register empty and no pending lastSet, busy clears on that word's last sample enable and underrun rises. Underrun stays high until the next word is written.
- R12: While idle, the first sample enable after a write starts the word (busy rises and the first step is added). The baud rate is captured with each word, so consecutive words may use different rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | One-clock sample-rate enable |
| loadValid | input | 1 | Writes loadData and baudSel into the holding register |
| loadData | input | 8 | Data word, sent MSB first |
| baudSel | input | 1 | 0 = 1200 baud, 1 = 2400 baud, captured with the word |
| lastSet | input | 1 | Marks the transmission end; a hang bit follows the final word |
| irqEn | input | 1 | Enables the completion interrupt |
| phaseOut | output | 16 | Phase accumulator sample |
| toneSign | output | 1 | Square-wave tone (phase MSB) |
| busy | output | 1 | Modulator is sending |
| doneIrq | output | 1 | One-clock pulse when the hang bit has left |
| underrun | output | 1 | Sticky flag: the data ran out without last-data |

## Verification
Every output here is a registered result of the sample-enable edge. The phase step, busy change, interrupt pulse and underrun rise for a sample are all visible just after the clock edge where sampleEn was high, and not one edge later. The bench registers its own copy of sampleEn. On the falling edge that follows each enable edge, the monitor pops exactly one expected item and compares it. On every other falling edge, it checks that the phase has not moved. Writes and lastSet pulses are placed on clocks without an enable, so the position of each word boundary in the expected stream is fixed by sample count alone.

// File: rtl/ffsk_pkg.sv
package ffsk_pkg;

  // Strobes from the sequencer to the datapath, at most one load/shift kind per clock.
  typedef struct packed {
    logic advance;    // add one phase step this clock
    logic startWord;  // idle start: step uses the held word, then the shifter takes it
    logic shiftBit;   // move to the next bit of the current word
    logic loadNext;   // word boundary: the shifter takes the held word
  } ffskStrobe_t;

  // Phase increment for a tone, given the accumulator width and the sample rate.
  function automatic longint unsigned toneStep(input longint unsigned freqHz,
                                               input int phaseW,
                                               input longint unsigned rateHz);
    return (freqHz << phaseW) / rateHz;
  endfunction

endpackage

// File: rtl/ffsk_datapath.sv
module ffsk_datapath
  import ffsk_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int PHASE_W     = 16,
  parameter int SAMPLE_RATE = 9600,
  parameter int MARK_HZ     = 1200,
  parameter int SPACE_LO_HZ = 1800,
  parameter int SPACE_HI_HZ = 2400
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadValid,
  input  logic [WORD_W-1:0]  loadData,
  input  logic               baudSel,
  input  ffskStrobe_t        st,
  output logic               holdFull,
  output logic               baudQ,
  output logic [PHASE_W-1:0] phaseOut
);

  localparam int STEP_N = 4;  // index {baud, bit}

  logic [WORD_W-1:0]  holdWord;
  logic               holdBaud;
  logic [WORD_W-1:0]  shiftReg;
  logic [PHASE_W-1:0] phaseAcc;
  logic [PHASE_W-1:0] stepTable [STEP_N];
  logic               bitNow;
  logic               baudNow;
  logic [PHASE_W-1:0] stepNow;
  logic               consume;

  // One increment per (baud, bit) pair; a 1 is always the mark tone.
  for (genvar k = 0; k < STEP_N; k++) begin : g_step
    localparam longint unsigned FREQ =
      (k % 2 == 1) ? longint'(MARK_HZ) :
      ((k / 2 == 1) ? longint'(SPACE_HI_HZ) : longint'(SPACE_LO_HZ));
    assign stepTable[k] = PHASE_W'(toneStep(FREQ, PHASE_W, longint'(SAMPLE_RATE)));
  end

  // On an idle start the first sample belongs to the word still in the holding register.
  assign bitNow  = st.startWord ? holdWord[WORD_W-1] : shiftReg[WORD_W-1];
  assign baudNow = st.startWord ? holdBaud : baudQ;
  assign stepNow = stepTable[{baudNow, bitNow}];
  assign consume = st.startWord | st.loadNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdWord <= '0;
      holdBaud <= 1'b0;
      holdFull <= 1'b0;
      shiftReg <= '0;
      baudQ    <= 1'b0;
      phaseAcc <= '0;
    end else begin
      if (consume) begin
        shiftReg <= holdWord;
        baudQ    <= holdBaud;
      end else if (st.shiftBit) begin
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
      end

      if (st.advance) phaseAcc <= phaseAcc + stepNow;

      // A host write wins over a same-clock hand-off into the shifter.
      if (loadValid) begin
        holdWord <= loadData;
        holdBaud <= baudSel;
        holdFull <= 1'b1;
      end else if (consume) begin
        holdFull <= 1'b0;
      end
    end
  end

  assign phaseOut = phaseAcc;

  // R6: the accumulator only moves when the sequencer asks for a step.
  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !st.advance |=> $stable(phaseAcc));

  // R8: a hand-off empties the holding register unless the host refills it.
  assert_hold_consumed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (consume && !loadValid) |=> !holdFull);

endmodule

// File: rtl/ffsk_control.sv
module ffsk_control
  import ffsk_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SAMPLE_RATE = 9600,
  parameter int BAUD_LO     = 1200,
  parameter int BAUD_HI     = 2400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleEn,
  input  logic        holdFull,
  input  logic        baudQ,
  input  logic        lastSet,
  input  logic        irqEn,
  input  logic        loadValid,
  output ffskStrobe_t st,
  output logic        busy,
  output logic        doneIrq,
  output logic        underrun
);

  localparam int LEN_LO = SAMPLE_RATE / BAUD_LO;
  localparam int LEN_HI = SAMPLE_RATE / BAUD_HI;
  localparam int CNT_W  = $clog2(LEN_LO + 1);
  localparam int BIT_W  = $clog2(WORD_W + 1);

  logic [CNT_W-1:0] sampleCnt;
  logic [CNT_W-1:0] bitLen;
  logic [BIT_W-1:0] bitsLeft;
  logic             inHang;
  logic             lastPending;
  logic             endBit;

  assign bitLen = baudQ ? CNT_W'(LEN_HI) : CNT_W'(LEN_LO);

  always_comb begin
    st     = '0;
    endBit = 1'b0;
    if (sampleEn) begin
      if (!busy) begin
        if (holdFull) begin
          st.advance   = 1'b1;
          st.startWord = 1'b1;
        end
      end else begin
        st.advance = 1'b1;
        endBit     = (sampleCnt == bitLen - CNT_W'(1));
        if (endBit && !inHang) begin
          if (bitsLeft > BIT_W'(1)) st.shiftBit = 1'b1;
          else if (holdFull)        st.loadNext = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= 1'b0;
      doneIrq     <= 1'b0;
      underrun    <= 1'b0;
      inHang      <= 1'b0;
      lastPending <= 1'b0;
      sampleCnt   <= '0;
      bitsLeft    <= '0;
    end else begin
      doneIrq <= 1'b0;
      if (st.startWord) begin
        busy      <= 1'b1;
        sampleCnt <= CNT_W'(1);  // the start clock already sent one sample
        bitsLeft  <= BIT_W'(WORD_W);
      end else if (st.advance) begin
        if (!endBit) begin
          sampleCnt <= sampleCnt + CNT_W'(1);
        end else begin
          sampleCnt <= '0;
          if (inHang) begin
            busy        <= 1'b0;
            inHang      <= 1'b0;
            lastPending <= 1'b0;
            doneIrq     <= irqEn;
          end else if (st.shiftBit) begin
            bitsLeft <= bitsLeft - BIT_W'(1);
          end else if (st.loadNext) begin
            bitsLeft <= BIT_W'(WORD_W);
          end else if (lastPending) begin
            inHang <= 1'b1;  // shifter is not moved: the hang bit repeats the last bit
          end else begin
            busy     <= 1'b0;
            underrun <= 1'b1;
          end
        end
      end
      if (lastSet)   lastPending <= 1'b1;
      if (loadValid) underrun    <= 1'b0;
    end
  end

  // R2: the sample counter stays inside the current bit length.
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (sampleCnt < bitLen));

  // R10: the interrupt marks the end of busy and needs the enable.
  assert_irq_after_hang_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (!busy && $past(busy) && $past(irqEn)));

  // R11: an underrun stops the modulator without an interrupt.
  assert_underrun_stop_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> ($fell(busy) && !doneIrq));

  // R12: a word only starts on a sample enable.
  assert_start_on_tick_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(sampleEn));

endmodule

// File: rtl/ffsk_modulator.sv
module ffsk_modulator
  import ffsk_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int PHASE_W     = 16,
  parameter int SAMPLE_RATE = 9600,
  parameter int BAUD_LO     = 1200,
  parameter int BAUD_HI     = 2400,
  parameter int MARK_HZ     = 1200,
  parameter int SPACE_LO_HZ = 1800,
  parameter int SPACE_HI_HZ = 2400
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleEn,
  input  logic               loadValid,
  input  logic [WORD_W-1:0]  loadData,
  input  logic               baudSel,
  input  logic               lastSet,
  input  logic               irqEn,
  output logic [PHASE_W-1:0] phaseOut,
  output logic               toneSign,
  output logic               busy,
  output logic               doneIrq,
  output logic               underrun
);

  ffskStrobe_t st;
  logic        holdFull;
  logic        baudQ;

  ffsk_control #(
    .WORD_W(WORD_W), .SAMPLE_RATE(SAMPLE_RATE), .BAUD_LO(BAUD_LO), .BAUD_HI(BAUD_HI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .holdFull(holdFull), .baudQ(baudQ),
    .lastSet(lastSet), .irqEn(irqEn), .loadValid(loadValid), .st(st),
    .busy(busy), .doneIrq(doneIrq), .underrun(underrun)
  );

  ffsk_datapath #(
    .WORD_W(WORD_W), .PHASE_W(PHASE_W), .SAMPLE_RATE(SAMPLE_RATE),
    .MARK_HZ(MARK_HZ), .SPACE_LO_HZ(SPACE_LO_HZ), .SPACE_HI_HZ(SPACE_HI_HZ)
  ) u_dp (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadData(loadData),
    .baudSel(baudSel), .st(st), .holdFull(holdFull), .baudQ(baudQ), .phaseOut(phaseOut)
  );

  assign toneSign = phaseOut[PHASE_W-1];

  // R6: without a sample enable the output sample holds.
  assert_no_tick_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(phaseOut));

endmodule

// File: tb/tb_ffsk_modulator.sv
module tb_ffsk_modulator;

  localparam int TAIL_NEXT  = 0;
  localparam int TAIL_HANG  = 1;
  localparam int TAIL_UNDER = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleEn = 1'b0;
  logic        loadValid = 1'b0;
  logic [7:0]  loadData = '0;
  logic        baudSel = 1'b0;
  logic        lastSet = 1'b0;
  logic        irqEn = 1'b0;
  logic [15:0] phaseOut;
  logic        toneSign;
  logic        busy;
  logic        doneIrq;
  logic        underrun;

  always #5 clk = ~clk;

  ffsk_modulator dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .loadValid(loadValid),
    .loadData(loadData), .baudSel(baudSel), .lastSet(lastSet), .irqEn(irqEn),
    .phaseOut(phaseOut), .toneSign(toneSign), .busy(busy), .doneIrq(doneIrq),
    .underrun(underrun)
  );

  typedef struct {
    logic [15:0] ph;
    logic        bsy;
    logic        irq;
    logic        und;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  int          vectors = 0;
  int          miscompares = 0;
  logic [15:0] mPhase = '0;
  logic        mUnder = 1'b0;
  logic [15:0] lastPhase = '0;
  logic        tickReg = 1'b0;
  logic        running = 1'b0;

  function automatic void check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endfunction

  // Bench copy of the enable, so the monitor knows which falling edges follow a step.
  always @(posedge clk) tickReg <= sampleEn;

  // Monitor: one expected item per sample-enable edge; otherwise the phase must hold.
  always @(negedge clk) begin
    if (running) begin
      if (tickReg) begin
        if (expQ.size() == 0) begin
          check("R12", "unexpected tick, queue empty", 32'd1, 32'd0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(e.tag, "phaseOut", 32'(phaseOut), 32'(e.ph));
          check({e.tag, " R6"}, "toneSign", 32'(toneSign), 32'(e.ph[15]));
          check(e.tag, "busy", 32'(busy), 32'(e.bsy));
          check({e.tag, " R10"}, "doneIrq", 32'(doneIrq), 32'(e.irq));
          check({e.tag, " R11"}, "underrun", 32'(underrun), 32'(e.und));
          lastPhase = e.ph;
        end
      end else begin
        check("R6", "phase moved without enable", 32'(phaseOut), 32'(lastPhase));
      end
    end
  end

  // Steps from R2..R5: mark 8192; space 12288 (1200 baud) or 16384 (2400 baud).
  function automatic logic [15:0] stepOf(logic b, logic hi);
    if (b) return 16'd8192;
    return hi ? 16'd16384 : 16'd12288;
  endfunction

  // Driver model: push one item per sample enable for a word (MSB first, R7).
  task automatic expectWord(input logic [7:0] w, input logic hi, input int tail,
                            input logic irqOn, input string tag);
    int len = hi ? 4 : 8;
    int nBits = (tail == TAIL_HANG) ? 9 : 8;
    mUnder = 1'b0;
    for (int b = 0; b < nBits; b++) begin
      logic bitV = (b < 8) ? w[7 - b] : w[0];  // hang bit repeats the LSB (R9)
      for (int s = 0; s < len; s++) begin
        expItem_t e;
        logic isLast = (b == nBits - 1) && (s == len - 1);
        mPhase = mPhase + stepOf(bitV, hi);
        e.ph  = mPhase;
        e.bsy = 1'b1;
        e.irq = 1'b0;
        if (isLast && tail == TAIL_HANG) begin
          e.bsy = 1'b0;
          e.irq = irqOn;
        end
        if (isLast && tail == TAIL_UNDER) begin
          e.bsy  = 1'b0;
          mUnder = 1'b1;
        end
        e.und = mUnder;
        e.tag = tag;
        expQ.push_back(e);
      end
    end
  endtask

  task automatic expectIdle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      expItem_t e;
      e.ph = mPhase; e.bsy = 1'b0; e.irq = 1'b0; e.und = mUnder; e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sampleEn = 1'b1;
      @(negedge clk) sampleEn = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic loadWord(input logic [7:0] w, input logic hi);
    @(negedge clk);
    loadValid = 1'b1; loadData = w; baudSel = hi;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic pulseLast();
    @(negedge clk) lastSet = 1'b1;
    @(negedge clk) lastSet = 1'b0;
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "phaseOut", 32'(phaseOut), 32'd0);
    check("R1", "busy", 32'(busy), 32'd0);
    check("R1", "doneIrq", 32'(doneIrq), 32'd0);
    check("R1", "underrun", 32'(underrun), 32'd0);
    running = 1'b1;

    // 0xA5 at 1200 baud, terminated: R2 R3 R7 R9 R10 (irq enabled)
    irqEn = 1'b1;
    expectWord(8'hA5, 1'b0, TAIL_HANG, 1'b1, "R2 R3 R7 R9 R10");
    expectIdle(1, "R9 idle after hang");
    loadWord(8'hA5, 1'b0);
    pulseLast();
    runTicks(73);

    // Back to back at 2400 baud, then underrun: R4 R5 R8 R11
    expectWord(8'h3C, 1'b1, TAIL_NEXT, 1'b0, "R4 R5 R8");
    expectWord(8'h81, 1'b1, TAIL_UNDER, 1'b0, "R8 R11");
    expectIdle(3, "R11 sticky underrun");
    loadWord(8'h3C, 1'b1);
    runTicks(5);
    loadWord(8'h81, 1'b1);
    runTicks(59 + 3);

    // Mixed baud per word, hang at 2400, interrupt disabled: R12 R9 R10
    irqEn = 1'b0;
    expectWord(8'hF0, 1'b0, TAIL_NEXT, 1'b0, "R12 R11 clear");
    expectWord(8'h0F, 1'b1, TAIL_HANG, 1'b0, "R12 R9 R10 masked");
    expectIdle(2, "R12 idle");
    loadWord(8'hF0, 1'b0);
    runTicks(3);
    loadWord(8'h0F, 1'b1);
    pulseLast();
    runTicks(64 + 36 - 3 + 2);

    repeat (2) @(negedge clk);
    running = 1'b0;
    check("R12", "leftover expected items", 32'(expQ.size()), 32'd0);
    finishRun();
  end

endmodule